// File: doc/BRIEF.md
# Low-Power Entry Control and Reset Cause Register Block

This block holds the register set that a microcontroller's system integration logic uses to decide whether the core may enter its two low-power states, to force the debug clock on, to request a software reset, and to record why the device last reset. Software reaches it over a simple synchronous register bus: address, write strobe and write data go in, and read data comes back one clock after the address is presented.

The core raises a stop request or a wait request. The block passes each request on as a grant in the same cycle, or holds it back, according to a two-bit disable field per state. Each field can allow entry, block entry while staying writable, or block entry and refuse further writes until the next device reset. A separate reset-cause register collects one sticky bit per reset source. A non-power-on reset can set these bits but never clears them. Only a power-on reset or a write-one-to-clear access from software clears them.

Two reset inputs come in. `rst` is any device reset and clears the control state. `por` is a power-on reset: it also clears the control state, and it is the only reset that initializes the cause register.

Top module: `pmc_ctrl_regs`

## Requirements
- R1: The control register is read at address 0, with read data valid one cycle after the address. Its bits 15 to 6 and bit 4 always read as 0, and writing 1s to bits 15 to 6 changes nothing.
- R2: Control bit 5 selects the debug clock enable. When it is 0, `dbg_clk_en` follows `tap_en`. When it is 1, `dbg_clk_en` is 1.
- R3: Writing 1 to control bit 4 drives `swrst_pulse` high for exactly the one cycle after the write. Writing 0 to that bit gives no pulse.
- R4: Control bits 3:2 form the stop field. With value 00, `stop_grant` equals `stop_req` in the same cycle. With value 01, `stop_grant` is 0 and the field can still be rewritten.
- R5: Stop field values 10 and 11 hold `stop_grant` at 0 and lock the field. Later writes leave the field unchanged until `rst` or `por` is asserted.
- R6: Control bits 1:0 form the wait field. It follows the same encoding and lock rules as the stop field, but acts on `wait_req` and `wait_grant`.
- R7: While `rst` or `por` is asserted, every control field, including the locks, is cleared to 0 and the read data is 0.
- R8: The cause register is read at address 1, and its bits 15 to 5 read as 0. Its bit positions are: 0 power-on, 1 external pin, 2 software, 3 watchdog, 4 clock loss. Asserting `por` sets it to 0x0001.
- R9: A pulse on a cause input sets its bit in the next cycle. A `swrst_pulse` sets bit 2 in the cycle after it. Asserting `rst` without `por` clears no bit.
- R10: Writing the cause register clears each bit written as 1 and keeps each bit written as 0. When a cause arrives in the same cycle as the clear of its own bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Device reset, synchronous, active high |
| por | input | 1 | Power-on reset, synchronous, active high |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tap_en | input | 1 | Debug test access port enabled |
| stop_req | input | 1 | Core requests stop entry |
| wait_req | input | 1 | Core requests wait entry |
| pin_rst_evt | input | 1 | External pin reset occurred |
| wdog_rst_evt | input | 1 | Watchdog reset occurred |
| clk_loss_evt | input | 1 | Loss-of-clock reset occurred |
| stop_grant | output | 1 | Stop entry permitted |
| wait_grant | output | 1 | Wait entry permitted |
| dbg_clk_en | output | 1 | Debug clock enable to the core |
| swrst_pulse | output | 1 | Software reset request pulse |

## Verification
Random control writes with all four field codes exercise the grant gating against a bench model of each field. Drawing from all four codes tells the writable block code apart from the two locking codes, and a locked field apart from a field that has simply been rewritten. Random plain resets are mixed in, so the bench sees locks released while the sticky cause bits survive. Directed cases set a cause and clear it in the same cycle, write only to the high bits, and then apply a power-on reset. These separate set priority, ignored bits and the full reinitialisation of the cause register from the ordinary reset path.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    LPM_ALLOW    = 2'b00,
    LPM_BLOCK    = 2'b01,
    LPM_LOCK     = 2'b10,
    LPM_LOCK_ALT = 2'b11
  } lpm_mode_e;

  localparam int CAUSE_N   = 5;
  localparam int C_POR     = 0;
  localparam int C_PIN     = 1;
  localparam int C_SOFT    = 2;
  localparam int C_WDOG    = 3;
  localparam int C_CLKLOSS = 4;

  localparam int CTL_USED  = 6;
  localparam int B_DBG     = 5;
  localparam int B_SWRST   = 4;
  localparam int LPM_W     = 2;
  localparam int LPM_N     = 2;  // index 0 = wait, 1 = stop
endpackage

// File: rtl/pmc_lpm_gate.sv
module pmc_lpm_gate
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             dev_rst,
  input  logic             wr_en,
  input  logic [LPM_W-1:0] wr_mode,
  input  logic             req,
  output logic [LPM_W-1:0] mode,
  output logic             grant
);
  logic locked;
  assign locked = mode[1];

  always_ff @(posedge clk) begin
    if (dev_rst) begin
      mode <= LPM_ALLOW;
    end else if (wr_en && !locked) begin
      mode <= wr_mode;
    end
  end

  assign grant = req && (mode == LPM_ALLOW);

  // R5 / R6: a locked field keeps its code until a device reset
  assert_lock_hold_R5: assert property (@(posedge clk) disable iff (dev_rst)
    locked |=> (mode == $past(mode)));

  // R5 / R6: writing a locking code blocks entry from the next cycle on
  assert_lock_blocks_R6: assert property (@(posedge clk) disable iff (dev_rst)
    (wr_en && !locked && wr_mode[1]) |=> !grant);
endmodule

// File: rtl/pmc_rst_status.sv
module pmc_rst_status
  import pmc_pkg::*;
(
  input  logic               clk,
  input  logic               por,
  input  logic               clr_en,
  input  logic [CAUSE_N-1:0] clr_mask,
  input  logic [CAUSE_N-1:0] cause,
  output logic [CAUSE_N-1:0] sts
);
  logic [CAUSE_N-1:0] clr_eff;
  assign clr_eff = clr_en ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (por) begin
      sts <= CAUSE_N'(1) << C_POR;
    end else begin
      sts <= (sts & ~clr_eff) | cause;
    end
  end

  // R9: without a clearing write, no set bit is lost (plain resets included)
  assert_sticky_R9: assert property (@(posedge clk) disable iff (por)
    !clr_en |=> ((sts & $past(sts)) == $past(sts)));

  // R10: a cause always wins over a same-cycle clear of its bit
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (por)
    cause[C_WDOG] |=> sts[C_WDOG]);
endmodule

// File: rtl/pmc_ctrl_regs.sv
module pmc_ctrl_regs
  import pmc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int CTL_ADDR = 0,
  parameter int STS_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tap_en,
  input  logic              stop_req,
  input  logic              wait_req,
  input  logic              pin_rst_evt,
  input  logic              wdog_rst_evt,
  input  logic              clk_loss_evt,
  output logic              stop_grant,
  output logic              wait_grant,
  output logic              dbg_clk_en,
  output logic              swrst_pulse
);
  localparam int CTL_PAD = DATA_W - CTL_USED;
  localparam int STS_PAD = DATA_W - CAUSE_N;

  logic dev_rst;
  logic ctl_wr, sts_wr;
  logic dbg_force;
  logic [LPM_N-1:0] lpm_req, lpm_grant;
  logic [LPM_W-1:0] lpm_mode [LPM_N];
  logic [CAUSE_N-1:0] cause_vec, sts;

  assign dev_rst = rst || por;
  assign ctl_wr  = bus_wr && (bus_addr == ADDR_W'(CTL_ADDR));
  assign sts_wr  = bus_wr && (bus_addr == ADDR_W'(STS_ADDR));

  assign lpm_req = {stop_req, wait_req};

  for (genvar g = 0; g < LPM_N; g++) begin : g_lpm
    pmc_lpm_gate u_gate (
      .clk     (clk),
      .dev_rst (dev_rst),
      .wr_en   (ctl_wr),
      .wr_mode (bus_wdata[g*LPM_W +: LPM_W]),
      .req     (lpm_req[g]),
      .mode    (lpm_mode[g]),
      .grant   (lpm_grant[g])
    );
  end

  assign wait_grant = lpm_grant[0];
  assign stop_grant = lpm_grant[1];

  always_ff @(posedge clk) begin
    if (dev_rst) begin
      dbg_force   <= 1'b0;
      swrst_pulse <= 1'b0;
    end else begin
      if (ctl_wr) dbg_force <= bus_wdata[B_DBG];
      swrst_pulse <= ctl_wr && bus_wdata[B_SWRST];
    end
  end

  assign dbg_clk_en = dbg_force || tap_en;

  always_comb begin
    cause_vec            = '0;
    cause_vec[C_PIN]     = pin_rst_evt;
    cause_vec[C_SOFT]    = swrst_pulse;
    cause_vec[C_WDOG]    = wdog_rst_evt;
    cause_vec[C_CLKLOSS] = clk_loss_evt;
  end

  pmc_rst_status u_sts (
    .clk      (clk),
    .por      (por),
    .clr_en   (sts_wr),
    .clr_mask (bus_wdata[CAUSE_N-1:0]),
    .cause    (cause_vec),
    .sts      (sts)
  );

  always_ff @(posedge clk) begin
    if (dev_rst) begin
      bus_rdata <= '0;
    end else if (bus_addr == ADDR_W'(CTL_ADDR)) begin
      bus_rdata <= {{CTL_PAD{1'b0}}, dbg_force, 1'b0, lpm_mode[1], lpm_mode[0]};
    end else if (bus_addr == ADDR_W'(STS_ADDR)) begin
      bus_rdata <= {{STS_PAD{1'b0}}, sts};
    end else begin
      bus_rdata <= '0;
    end
  end

  // R1: high control bits written as ones never appear on the read port
  assert_upper_ignored_R1: assert property (@(posedge clk) disable iff (dev_rst)
    (ctl_wr && (bus_wdata[DATA_W-1:CTL_USED] != '0)) |=> (bus_rdata[DATA_W-1:CTL_USED] == '0));

  // R3: every software reset pulse is recorded as a software cause
  assert_swrst_logged_R3: assert property (@(posedge clk) disable iff (por)
    swrst_pulse |=> sts[C_SOFT]);

  // R7: after a reset cycle the control state and read port are clear
  assert_reset_clears_R7: assert property (@(posedge clk)
    dev_rst |=> (bus_rdata == '0 && !swrst_pulse && !dbg_force));
endmodule

// File: tb/pmc_ctrl_regs_test.sv
`timescale 1ns/1ps
module pmc_ctrl_regs_test;
  logic        clk = 0;
  logic        rst = 1, por = 1;
  logic [3:0]  bus_addr = 0;
  logic        bus_wr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        tap_en = 0, stop_req = 0, wait_req = 0;
  logic        pin_rst_evt = 0, wdog_rst_evt = 0, clk_loss_evt = 0;
  logic        stop_grant, wait_grant, dbg_clk_en, swrst_pulse;

  int checks = 0;
  int fails  = 0;

  logic [1:0] m_stop, m_wait;
  logic       m_dbg;
  logic [4:0] m_sts;

  pmc_ctrl_regs uut (
    .clk(clk), .rst(rst), .por(por), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tap_en(tap_en),
    .stop_req(stop_req), .wait_req(wait_req), .pin_rst_evt(pin_rst_evt),
    .wdog_rst_evt(wdog_rst_evt), .clk_loss_evt(clk_loss_evt),
    .stop_grant(stop_grant), .wait_grant(wait_grant),
    .dbg_clk_en(dbg_clk_en), .swrst_pulse(swrst_pulse)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] exp_ctl();
    return {10'd0, m_dbg, 1'b0, m_stop, m_wait};
  endfunction

  function automatic logic exp_grant(input logic req, input logic [1:0] mode);
    return req && (mode == 2'b00);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
    if (a == 0) begin
      if (!m_stop[1]) m_stop = d[3:2];
      if (!m_wait[1]) m_wait = d[1:0];
      m_dbg = d[5];
      if (d[4]) m_sts[2] = 1'b1;
    end else if (a == 1) begin
      m_sts = m_sts & ~d[4:0];
    end
    @(negedge clk);  // let a software pulse reach the cause register
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic plain_reset();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    m_stop = 0; m_wait = 0; m_dbg = 0;
  endtask

  task automatic check_grants(input string tag);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      {stop_req, wait_req} = 2'(k);
      #1;
      check({tag, " stop grant"}, 32'(stop_grant), 32'(exp_grant(stop_req, m_stop)));
      check({tag, " wait grant"}, 32'(wait_grant), 32'(exp_grant(wait_req, m_wait)));
    end
    stop_req = 0; wait_req = 0;
  endtask

  initial begin
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic pulse_seen;
    void'($urandom(32'd2024));
    m_stop = 0; m_wait = 0; m_dbg = 0; m_sts = 5'b00001;
    repeat (3) @(negedge clk);
    rst = 0; por = 0;

    // R7 / R8: state after power-on reset
    rd(0, v); check("R7 ctl after reset", 32'(v), 32'h0);
    rd(1, v); check("R8 cause after por", 32'(v), 32'h0001);
    check_grants("R4 R6 reset");

    // R2: debug clock selection
    @(negedge clk); tap_en = 1; #1; check("R2 follow tap", 32'(dbg_clk_en), 32'd1);
    @(negedge clk); tap_en = 0; #1; check("R2 follow tap off", 32'(dbg_clk_en), 32'd0);
    wr(0, 16'h0020); check("R2 forced", 32'(dbg_clk_en), 32'd1);
    wr(0, 16'h0000); check("R2 released", 32'(dbg_clk_en), 32'd0);

    // R1: high bits and software bit read zero
    wr(0, 16'hFFC0); rd(0, v); check("R1 high bits ignored", 32'(v), 32'(exp_ctl()));

    // R3: software reset pulse, exactly one cycle after the write
    @(negedge clk); bus_addr = 0; bus_wr = 1; bus_wdata = 16'h0010;
    @(negedge clk); bus_wr = 0; bus_wdata = 0;
    check("R3 pulse high", 32'(swrst_pulse), 32'd1);
    @(negedge clk); check("R3 pulse one cycle", 32'(swrst_pulse), 32'd0);
    m_sts[2] = 1;
    rd(0, v); check("R1 R3 swrst reads zero", 32'(v), 32'(exp_ctl()));
    rd(1, v); check("R9 software cause", 32'(v), 32'(m_sts));

    // R4: block-but-writable, then allow
    wr(0, 16'h0004); check_grants("R4 block");
    wr(0, 16'h0000); check_grants("R4 reopened");
    // R5: lock stop field, further writes ignored
    wr(0, 16'h0008); wr(0, 16'h0000); check_grants("R5 locked");
    rd(0, v); check("R5 lock readback", 32'(v), 32'(exp_ctl()));
    // R6: lock wait field with code 11
    wr(0, 16'h0003); wr(0, 16'h0001); check_grants("R6 wait locked");
    rd(0, v); check("R6 lock readback", 32'(v), 32'(exp_ctl()));

    // R7 / R9: plain reset clears locks, keeps causes
    plain_reset();
    rd(0, v); check("R7 locks cleared", 32'(v), 32'h0);
    rd(1, v); check("R9 cause survives rst", 32'(v), 32'(m_sts));
    check_grants("R7 after rst");

    // R9: each cause input
    @(negedge clk); pin_rst_evt = 1; wdog_rst_evt = 1; clk_loss_evt = 1;
    @(negedge clk); pin_rst_evt = 0; wdog_rst_evt = 0; clk_loss_evt = 0;
    m_sts = m_sts | 5'b11010;
    rd(1, v); check("R9 causes set", 32'(v), 32'(m_sts));

    // R10: partial clear, then set-wins
    wr(1, 16'hFFE1); rd(1, v); check("R10 partial clear", 32'(v), 32'(m_sts));
    @(negedge clk); bus_addr = 1; bus_wr = 1; bus_wdata = 16'h001F; wdog_rst_evt = 1;
    @(negedge clk); bus_wr = 0; bus_wdata = 0; wdog_rst_evt = 0;
    m_sts = 5'b01000;
    rd(1, v); check("R10 set wins", 32'(v), 32'(m_sts));

    // Random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 4) begin
        logic [15:0] d;
        d = 16'($urandom());
        d[4] = ($urandom_range(0, 7) == 0);
        wr(0, d);
        check_grants("R4 R5 R6 random");
      end else if (op == 4) begin
        wr(1, 16'($urandom()));
      end else if (op == 5) begin
        logic [2:0] e;
        e = 3'($urandom());
        @(negedge clk); {pin_rst_evt, wdog_rst_evt, clk_loss_evt} = e;
        @(negedge clk); {pin_rst_evt, wdog_rst_evt, clk_loss_evt} = 0;
        if (e[2]) m_sts[1] = 1;
        if (e[1]) m_sts[3] = 1;
        if (e[0]) m_sts[4] = 1;
      end else if (op == 6) begin
        plain_reset();
      end else if (op == 7) begin
        rd(0, v); check("R1 R5 random ctl", 32'(v), 32'(exp_ctl()));
      end else begin
        rd(1, v); check("R8 R9 R10 random cause", 32'(v), 32'(m_sts));
      end
    end

    // R3: no pulse for a write with bit 4 clear
    plain_reset();
    @(negedge clk); bus_addr = 0; bus_wr = 1; bus_wdata = 16'h0020;
    @(negedge clk); bus_wr = 0; bus_wdata = 0; m_dbg = 1;
    pulse_seen = swrst_pulse;
    check("R3 no pulse", 32'(pulse_seen), 32'd0);

    // R8: power-on reset reinitialises the cause register
    @(negedge clk); por = 1;
    @(negedge clk); por = 0;
    m_sts = 5'b00001; m_stop = 0; m_wait = 0; m_dbg = 0;
    rd(1, v); check("R8 por reinit", 32'(v), 32'h0001);
    rd(0, v); check("R7 por clears ctl", 32'(v), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule